// File: doc/BRIEF.md
# Programmable chip-select address decoder

This block turns each bus cycle's 20-bit address into a set of active-low select lines. An upper memory window is pinned to the top of the 1 MB space. A lower window starts at address zero. A middle window is split into four equal quarters. Seven peripheral selects each cover one 256-byte page, at page offsets 0 to 6 above a shared programmable base, and that base can sit in either memory or I/O space. The decode is purely combinational from the cycle inputs, so every select is valid in the same cycle as the address.

A small register port sets the windows. The middle group and the peripheral group stay silent until software has touched their register, by either a read or a write. Two of the peripheral pins can be switched to carry the A2 and A1 bits latched from the most recent bus cycle. Each of the upper and lower windows has an address-disable bit, which raises `addr_dis` whenever that window's select fires.

Selects may overlap. The block drives every select that matches and never arbitrates between them. The origin flag, which says whether the CPU or DMA started the cycle, has no effect on the decode.

Top module: `chipsel_decoder`

## Requirements
- R1: After reset the upper register reads 0x8006 (enabled, 64 KB window, no address disable), and the other three registers read 0. The middle and peripheral groups are disabled and all four middle selects and all seven peripheral pins are high.
- R2: Register 0 controls the upper window: bit 15 enables it, bit 7 is address disable, and bits 2:0 hold a size code k. While enabled, `ucs_n` is low for a memory cycle whose address is at or above 2^20 − 1024·2^k.
- R3: Register 1 uses the same layout for the lower window. While enabled, `lcs_n` is low for a memory cycle whose address is below 1024·2^k.
- R4: Register 2 holds the middle base in bits 15:9 (these are address bits 19:13) and a size code k in bits 2:0, giving a block of 8192·2^k bytes aligned to its own size. Once register 2 has been read or written, a memory cycle inside that block drives low exactly one `mcs_n[i]`, where i is the quarter of the block that holds the address.
- R5: Register 3 holds a peripheral page base in bits 15:4. Once register 3 has been read or written, `pcs_n[n]` is low when the cycle's page equals (base + n), with the sum wrapping modulo the page-field width. Pin 4 has no external select and is always high.
- R6: Register 3 bit 3 chooses the peripheral space. When it is 1, only I/O cycles match, comparing address bits 15:8. When it is 0, only memory cycles match, comparing bits 19:8. The upper, lower and middle windows never assert on an I/O cycle.
- R7: The cycle-origin flag `cyc_dma` has no effect on any output.
- R8: When several windows contain the same address, all of the matching selects assert together.
- R9: When register 3 bit 2 is set, `pcs_n[6]` carries A2 and `pcs_n[5]` carries A1, both captured at the last clock edge on which `cyc_valid` was high.
- R10: `addr_dis` is high exactly when `ucs_n` is low with the upper disable bit set, or `lcs_n` is low with the lower disable bit set.
- R11: With `cyc_valid` low, no select asserts and `addr_dis` is low.
- R12: `reg_rdata` returns the register chosen by `reg_sel`, with unused bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms a group) |
| reg_sel | input | 2 | Register index 0..3 |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| cyc_valid | input | 1 | Bus cycle present |
| cyc_addr | input | 20 | Cycle address |
| cyc_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| cyc_dma | input | 1 | 1 = DMA-originated cycle |
| ucs_n | output | 1 | Upper window select |
| lcs_n | output | 1 | Lower window select |
| mcs_n | output | 4 | Middle quarter selects |
| pcs_n | output | 7 | Peripheral selects / latched A1 (pin 5), A2 (pin 6) |
| addr_dis | output | 1 | Address drive disable |

## Verification
The group-enable flags and the latched address bits are the only state apart from the registers. A wrong enable flag shows on the very next matching cycle as a missing or extra select. A wrong latch shows on pins 5 and 6 in the cycle after the capture. Corrupted configuration shows at once in `reg_rdata` and in a shifted window edge. For this reason the reference model is compared on every clock, including window boundaries, page-sum wrap and overlapping windows.

// File: rtl/csd_pkg.sv
package csd_pkg;
    localparam int ADDR_W     = 20;
    localparam int IO_W       = 16;
    localparam int PAGE_W     = 8;
    localparam int REG_W      = 16;
    localparam int N_MID      = 4;
    localparam int N_PER      = 7;
    localparam int SIZE_W     = 3;
    localparam int UL_MIN_LG  = 10;
    localparam int MID_MIN_LG = 13;
    localparam int NOPIN_IDX  = 4;
    localparam int LAT_IDX    = 5;   // pins LAT_IDX, LAT_IDX+1 carry A1, A2
    localparam int PER_BASE_W = ADDR_W - PAGE_W;
    localparam int IO_PAGE_W  = IO_W - PAGE_W;
    localparam int MID_BASE_W = ADDR_W - MID_MIN_LG;
    localparam int MID_IDX_W  = $clog2(N_MID);
    localparam int EN_BIT     = 15;
    localparam int ADIS_BIT   = 7;
    localparam int IO_BIT     = 3;
    localparam int LATCH_BIT  = 2;

    typedef enum logic [1:0] {
        RSEL_UPPER = 2'd0,
        RSEL_LOWER = 2'd1,
        RSEL_MID   = 2'd2,
        RSEL_PER   = 2'd3
    } rsel_e;

    typedef struct packed {
        logic              en;
        logic              adis;
        logic [SIZE_W-1:0] size;
    } mem_cfg_t;

    typedef struct packed {
        logic [MID_BASE_W-1:0] base;
        logic [SIZE_W-1:0]     size;
    } mid_cfg_t;

    typedef struct packed {
        logic [PER_BASE_W-1:0] base;
        logic                  io;
        logic                  latch;
    } per_cfg_t;

    typedef struct packed {
        mem_cfg_t up;
        mem_cfg_t lo;
        mid_cfg_t mid;
        per_cfg_t per;
        logic     mid_en;
        logic     per_en;
    } cfg_t;

    // Mask of the address bits at and above position lg.
    function automatic logic [ADDR_W-1:0] hi_mask(input int lg);
        return ~((ADDR_W'(1) << lg) - ADDR_W'(1));
    endfunction
endpackage

// File: rtl/csd_regs.sv
module csd_regs
    import csd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [1:0]       reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output cfg_t             cfg,
    output logic [REG_W-1:0] reg_rdata
);
    cfg_t cfg_q;
    logic touch;

    assign touch = reg_wr || reg_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q         <= '0;
            cfg_q.up.en   <= 1'b1;
            cfg_q.up.size <= SIZE_W'(6);
        end else begin
            if (reg_wr) begin
                case (reg_sel)
                    RSEL_UPPER: begin
                        cfg_q.up.en   <= reg_wdata[EN_BIT];
                        cfg_q.up.adis <= reg_wdata[ADIS_BIT];
                        cfg_q.up.size <= reg_wdata[SIZE_W-1:0];
                    end
                    RSEL_LOWER: begin
                        cfg_q.lo.en   <= reg_wdata[EN_BIT];
                        cfg_q.lo.adis <= reg_wdata[ADIS_BIT];
                        cfg_q.lo.size <= reg_wdata[SIZE_W-1:0];
                    end
                    RSEL_MID: begin
                        cfg_q.mid.base <= reg_wdata[REG_W-1 -: MID_BASE_W];
                        cfg_q.mid.size <= reg_wdata[SIZE_W-1:0];
                    end
                    default: begin
                        cfg_q.per.base  <= reg_wdata[REG_W-1 -: PER_BASE_W];
                        cfg_q.per.io    <= reg_wdata[IO_BIT];
                        cfg_q.per.latch <= reg_wdata[LATCH_BIT];
                    end
                endcase
            end
            if (touch && reg_sel == RSEL_MID) cfg_q.mid_en <= 1'b1;
            if (touch && reg_sel == RSEL_PER) cfg_q.per_en <= 1'b1;
        end
    end

    assign cfg = cfg_q;

    always_comb begin
        case (reg_sel)
            RSEL_UPPER: reg_rdata = {cfg_q.up.en, 7'b0, cfg_q.up.adis, 4'b0, cfg_q.up.size};
            RSEL_LOWER: reg_rdata = {cfg_q.lo.en, 7'b0, cfg_q.lo.adis, 4'b0, cfg_q.lo.size};
            RSEL_MID:   reg_rdata = {cfg_q.mid.base, 6'b0, cfg_q.mid.size};
            default:    reg_rdata = {cfg_q.per.base, cfg_q.per.io, cfg_q.per.latch, 2'b0};
        endcase
    end

    logic unused_wbits;
    assign unused_wbits = ^{reg_wdata[14:8], reg_wdata[6:3]};
endmodule

// File: rtl/csd_mem_dec.sv
module csd_mem_dec
    import csd_pkg::*;
(
    input  logic              cyc_valid,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic              cyc_io,
    input  mem_cfg_t          up,
    input  mem_cfg_t          lo,
    input  mid_cfg_t          mid,
    input  logic              mid_en,
    output logic              ucs,
    output logic              lcs,
    output logic [N_MID-1:0]  mcs
);
    logic                 mem_cyc;
    logic [ADDR_W-1:0]    m_up, m_lo, m_mid, mid_base;
    int                   mid_lg;
    logic                 mid_hit;
    logic [MID_IDX_W-1:0] quarter;

    always_comb begin
        mem_cyc  = cyc_valid && !cyc_io;
        m_up     = hi_mask(UL_MIN_LG + int'(up.size));
        m_lo     = hi_mask(UL_MIN_LG + int'(lo.size));
        mid_lg   = MID_MIN_LG + int'(mid.size);
        m_mid    = hi_mask(mid_lg);
        mid_base = {mid.base, {MID_MIN_LG{1'b0}}};
        ucs      = mem_cyc && up.en && ((cyc_addr & m_up) == m_up);
        lcs      = mem_cyc && lo.en && ((cyc_addr & m_lo) == '0);
        mid_hit  = mem_cyc && mid_en && ((cyc_addr & m_mid) == (mid_base & m_mid));
        quarter  = MID_IDX_W'(cyc_addr >> (mid_lg - MID_IDX_W));
    end

    for (genvar i = 0; i < N_MID; i++) begin : g_mid
        assign mcs[i] = mid_hit && (quarter == MID_IDX_W'(i));
    end
endmodule

// File: rtl/csd_per_dec.sv
module csd_per_dec
    import csd_pkg::*;
(
    input  logic                  cyc_valid,
    input  logic [PER_BASE_W-1:0] cyc_page,
    input  logic                  cyc_io,
    input  logic [PER_BASE_W-1:0] base,
    input  logic                  io_space,
    input  logic                  per_en,
    output logic [N_PER-1:0]      hit
);
    logic armed;
    assign armed = cyc_valid && per_en && (cyc_io == io_space);

    for (genvar n = 0; n < N_PER; n++) begin : g_per
        if (n == NOPIN_IDX) begin : g_nopin
            assign hit[n] = 1'b0;
        end else begin : g_pin
            logic [PER_BASE_W-1:0] tgt;
            logic                  page_eq;
            assign tgt     = base + PER_BASE_W'(n);
            assign page_eq = io_space ? (cyc_page[IO_PAGE_W-1:0] == tgt[IO_PAGE_W-1:0])
                                      : (cyc_page == tgt);
            assign hit[n]  = armed && page_eq;
        end
    end
endmodule

// File: rtl/chipsel_decoder.sv
module chipsel_decoder
    import csd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              cyc_valid,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic              cyc_io,
    input  logic              cyc_dma,
    output logic              ucs_n,
    output logic              lcs_n,
    output logic [N_MID-1:0]  mcs_n,
    output logic [N_PER-1:0]  pcs_n,
    output logic              addr_dis
);
    cfg_t             cfg;
    logic             ucs, lcs;
    logic [N_MID-1:0] mcs;
    logic [N_PER-1:0] phit;
    logic [1:0]       lat_q;

    csd_regs i_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .cfg(cfg), .reg_rdata(reg_rdata)
    );

    csd_mem_dec i_mem (
        .cyc_valid(cyc_valid), .cyc_addr(cyc_addr), .cyc_io(cyc_io),
        .up(cfg.up), .lo(cfg.lo), .mid(cfg.mid), .mid_en(cfg.mid_en),
        .ucs(ucs), .lcs(lcs), .mcs(mcs)
    );

    csd_per_dec i_per (
        .cyc_valid(cyc_valid), .cyc_page(cyc_addr[ADDR_W-1:PAGE_W]), .cyc_io(cyc_io),
        .base(cfg.per.base), .io_space(cfg.per.io), .per_en(cfg.per_en), .hit(phit)
    );

    always_ff @(posedge clk) begin
        if (rst)            lat_q <= '0;
        else if (cyc_valid) lat_q <= cyc_addr[2:1];
    end

    assign ucs_n    = ~ucs;
    assign lcs_n    = ~lcs;
    assign mcs_n    = ~mcs;
    assign addr_dis = (ucs && cfg.up.adis) || (lcs && cfg.lo.adis);

    for (genvar n = 0; n < N_PER; n++) begin : g_pin
        if (n == LAT_IDX || n == LAT_IDX + 1) begin : g_lat
            assign pcs_n[n] = cfg.per.latch ? lat_q[n - LAT_IDX] : ~phit[n];
        end else begin : g_cs
            assign pcs_n[n] = ~phit[n];
        end
    end

    logic unused_origin;
    assign unused_origin = cyc_dma;
endmodule

// File: rtl/csd_checker.sv
module csd_checker
    import csd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cyc_valid,
    input logic [ADDR_W-1:0] cyc_addr,
    input logic              cyc_io,
    input logic              ucs_n,
    input logic              lcs_n,
    input logic [N_MID-1:0]  mcs_n,
    input logic [N_PER-1:0]  pcs_n,
    input logic              addr_dis
);
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (&mcs_n && &pcs_n));

    p_upper_top_r2: assert property (@(posedge clk) disable iff (rst)
        !ucs_n |-> &cyc_addr[ADDR_W-1 -: 3]);

    p_lower_bottom_r3: assert property (@(posedge clk) disable iff (rst)
        !lcs_n |-> (cyc_addr[ADDR_W-1 -: 3] == 3'b000));

    p_mid_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~mcs_n));

    p_nopin_high_r5: assert property (@(posedge clk) disable iff (rst)
        pcs_n[NOPIN_IDX]);

    p_io_no_mem_r6: assert property (@(posedge clk) disable iff (rst)
        (cyc_valid && cyc_io) |-> (ucs_n && lcs_n && &mcs_n));

    p_dis_needs_sel_r10: assert property (@(posedge clk) disable iff (rst)
        addr_dis |-> (!ucs_n || !lcs_n));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !cyc_valid |-> (ucs_n && lcs_n && &mcs_n && &pcs_n[LAT_IDX-1:0] && !addr_dis));
endmodule

bind chipsel_decoder csd_checker i_chk (
    .clk(clk), .rst(rst), .cyc_valid(cyc_valid), .cyc_addr(cyc_addr), .cyc_io(cyc_io),
    .ucs_n(ucs_n), .lcs_n(lcs_n), .mcs_n(mcs_n), .pcs_n(pcs_n), .addr_dis(addr_dis)
);

// File: tb/test_chipsel_decoder.sv
`timescale 1ns/1ps
module test_chipsel_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        cyc_valid = 1'b0;
    logic [19:0] cyc_addr = '0;
    logic        cyc_io = 1'b0, cyc_dma = 1'b0;
    logic        ucs_n, lcs_n, addr_dis;
    logic [3:0]  mcs_n;
    logic [6:0]  pcs_n;

    int nvec = 0, nfail = 0;
    bit done = 0;

    int regs [4];
    bit mid_en, per_en;
    bit lat1, lat2;
    const int wmask [4] = '{32'h8087, 32'h8087, 32'hFE07, 32'hFFFC};

    always #5 clk = ~clk;

    chipsel_decoder i_chipsel_decoder (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cyc_valid(cyc_valid),
        .cyc_addr(cyc_addr), .cyc_io(cyc_io), .cyc_dma(cyc_dma), .ucs_n(ucs_n),
        .lcs_n(lcs_n), .mcs_n(mcs_n), .pcs_n(pcs_n), .addr_dis(addr_dis)
    );

    task automatic model_reset();
        regs[0] = 32'h8006; regs[1] = 0; regs[2] = 0; regs[3] = 0;
        mid_en = 0; per_en = 0; lat1 = 0; lat2 = 0;
    endtask

    function automatic logic [29:0] expected();
        int  a = int'(cyc_addr);
        bit  mem = cyc_valid && !cyc_io;
        bit  eu, el, ed;
        logic [3:0] em = 4'hF;
        logic [6:0] ep = 7'h7F;
        int  usz = 1024 << (regs[0] & 7);
        int  lsz = 1024 << (regs[1] & 7);
        int  msz = 8192 << (regs[2] & 7);
        int  mbase = ((regs[2] >> 9) & 127) * 8192;
        int  pbase = (regs[3] >> 4) & 4095;
        bit  pio = regs[3][3];
        eu = mem && regs[0][15] && (a >= 1048576 - usz);
        el = mem && regs[1][15] && (a < lsz);
        if (mem && mid_en && (a / msz == mbase / msz))
            em[(a % msz) / (msz / 4)] = 1'b0;
        for (int n = 0; n < 7; n++) begin
            int tgt = pbase + n;
            bit h;
            if (n == 4) continue;
            if (pio) h = cyc_valid && cyc_io && (((a >> 8) & 255) == (tgt & 255));
            else     h = cyc_valid && !cyc_io && ((a >> 8) == (tgt & 4095));
            if (per_en && h) ep[n] = 1'b0;
        end
        if (regs[3][2]) begin ep[5] = lat1; ep[6] = lat2; end
        ed = (eu && regs[0][7]) || (el && regs[1][7]);
        return {~eu, ~el, em, ep, ed, 16'(regs[reg_sel])};
    endfunction

    task automatic step(input string req);
        logic [29:0] exp_v, got;
        #1;
        exp_v = expected();
        got   = {ucs_n, lcs_n, mcs_n, pcs_n, addr_dis, reg_rdata};
        nvec++;
        if (got !== exp_v) begin
            nfail++;
            $display("FAIL %s: addr=%05h got=%08h expected=%08h", req, cyc_addr, got, exp_v);
        end
        @(posedge clk);
        if (reg_wr) regs[reg_sel] = int'(reg_wdata) & wmask[reg_sel];
        if ((reg_wr || reg_rd) && reg_sel == 2) mid_en = 1;
        if ((reg_wr || reg_rd) && reg_sel == 3) per_en = 1;
        if (cyc_valid) begin lat1 = cyc_addr[1]; lat2 = cyc_addr[2]; end
        @(negedge clk);
    endtask

    task automatic cyc(input logic [19:0] a, input bit io, input bit dma, input string req);
        cyc_valid = 1; cyc_addr = a; cyc_io = io; cyc_dma = dma;
        step(req);
        cyc_valid = 0; cyc_dma = 0;
    endtask

    task automatic idle(input logic [19:0] a, input string req);
        cyc_valid = 0; cyc_addr = a;
        step(req);
    endtask

    task automatic wr(input logic [1:0] s, input logic [15:0] d, input string req);
        reg_wr = 1; reg_sel = s; reg_wdata = d;
        step(req);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [1:0] s, input string req);
        reg_rd = 1; reg_sel = s;
        step(req);
        reg_rd = 0;
    endtask

    initial begin
        model_reset();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 / R12 reset state
        idle(20'h00000, "R1");
        reg_sel = 2'd1; idle(20'h00000, "R1");
        reg_sel = 2'd0;
        // R2 default upper 64 KB window and its edges
        cyc(20'hFFFF0, 0, 0, "R2");
        cyc(20'hF0000, 0, 0, "R2");
        cyc(20'hEFFFF, 0, 0, "R2");
        cyc(20'hFFFF0, 1, 0, "R6");
        // R4 / R3 nothing before arming or enabling
        cyc(20'h00000, 0, 0, "R4");
        // R3 lower 4 KB window
        wr(2'd1, 16'h8002, "R12");
        cyc(20'h00FFF, 0, 0, "R3");
        cyc(20'h01000, 0, 0, "R3");
        // R4 middle at 0x20000, 16 KB
        wr(2'd2, 16'h2001, "R4");
        cyc(20'h20000, 0, 0, "R4");
        cyc(20'h21000, 0, 0, "R4");
        cyc(20'h23FFF, 0, 0, "R4");
        cyc(20'h24000, 0, 0, "R4");
        cyc(20'h1FFFF, 0, 0, "R4");
        cyc(20'h22000, 1, 0, "R6");
        // R5 peripheral silent until armed, then R8 overlap with lower
        cyc(20'h00010, 0, 0, "R5");
        rd(2'd3, "R5");
        cyc(20'h00010, 0, 0, "R8");
        cyc(20'h00400, 0, 0, "R5");
        cyc(20'h00600, 0, 0, "R5");
        cyc(20'h00700, 0, 0, "R5");
        // R6 / R7 I/O space peripherals
        wr(2'd3, 16'h0A08, "R6");
        cyc(20'h0A011, 1, 0, "R6");
        cyc(20'h0A2FF, 1, 0, "R6");
        cyc(20'h0A000, 0, 0, "R6");
        cyc(20'hF0A10, 1, 0, "R6");
        cyc(20'h0A2FF, 1, 1, "R7");
        cyc(20'h20000, 0, 1, "R7");
        // R5 / R8 base wrap at the top of memory
        wr(2'd3, 16'hFFE0, "R5");
        cyc(20'hFFE00, 0, 0, "R8");
        cyc(20'hFFF00, 0, 0, "R5");
        cyc(20'h00000, 0, 0, "R5");
        // R10 address disable on the upper window
        wr(2'd0, 16'h8086, "R10");
        cyc(20'hFFE00, 0, 0, "R10");
        cyc(20'hEFFFF, 0, 0, "R10");
        cyc(20'h00100, 0, 0, "R10");
        wr(2'd1, 16'h8082, "R10");
        cyc(20'h00100, 0, 0, "R10");
        // R9 latched address bits
        wr(2'd3, 16'h0A0C, "R9");
        cyc(20'h0A506, 1, 0, "R9");
        idle(20'h00000, "R9");
        cyc(20'h0A502, 1, 0, "R9");
        idle(20'h0A504, "R9");
        cyc(20'h00004, 0, 0, "R9");
        idle(20'hFFFFF, "R11");
        // R2 smallest window, R4 full-space middle
        wr(2'd0, 16'h8000, "R2");
        cyc(20'hFFC00, 0, 0, "R2");
        cyc(20'hFFBFF, 0, 0, "R2");
        wr(2'd2, 16'h0007, "R4");
        cyc(20'h40000, 0, 0, "R4");
        cyc(20'hC0001, 0, 0, "R4");
        // R11 idle with addresses that would match
        idle(20'h00000, "R11");
        idle(20'hFFE00, "R11");
        for (int s = 0; s < 4; s++) begin
            reg_sel = 2'(s);
            idle(20'h12345, "R12");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: got=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end
endmodule